// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block keeps the block states of several processor-side caches coherent over one shared broadcast bus. Each cache port holds a small fully-associative directory of block tags, each tagged Modified, Shared or Invalid. Local reads and writes either complete at once on a hit of sufficient permission, or raise a request to a round-robin bus arbiter. The granted cache places a read or write (invalidate) message on the bus, and every other cache snoops that message against its own directory in the same cycle.

One bus transaction takes one clock. In that cycle the block raises a memory fill strobe when the requester held nothing. A snoop writeback strobe is raised when another cache gives up a Modified copy. An eviction writeback strobe with its tag is raised when a full directory drops a Modified victim. A probe port returns the state each cache holds for any tag, so the system can observe coherence state without touching the access ports.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every cache reports Invalid (probe code 0) for every tag. Probe codes are 2 bits per cache, cache c at bits [2c+1:2c]: 0 Invalid, 1 Shared, 2 Modified.
- R2: A read of a block the cache holds Invalid needs the bus. When granted, it drives bus_write_o=0 and raises mem_fill_o, and the block is Shared in that cache from the next cycle.
- R3: A write to an Invalid or Shared block needs the bus. When granted, it drives bus_write_o=1, and the block becomes Modified. mem_fill_o is raised only if the block was Invalid. A write to a Modified block completes in its request cycle with no bus message.
- R4: A read of a Shared or Modified block completes (req_done_o high) in its request cycle with no bus message.
- R5: A cache snooping another cache's write invalidates its copy. A cache snooping another cache's read keeps a Shared copy Shared and demotes a Modified copy to Shared. A cache never reacts to its own message.
- R6: In the cycle a snooped read or write hits a Modified copy in another cache, mem_wb_o is high, and the tag to write back is bus_tag_o.
- R7: Address bits [4:0] are ignored: any two addresses in the same 32-byte-aligned range share one coherence state, and the tag is address bits [ADDR_W-1:5].
- R8: For any tag, at most one cache holds Modified, and while one does, no other cache holds Shared.
- R9: Requests that need the bus are granted one per cycle in round-robin order. Cache 0 has first priority after reset, and after a grant to cache i the search starts at cache i+1 (wrapping). A requester that is not granted stalls with req_done_o low.
- R10: A local hit that needs no bus is stalled for one cycle if its tag equals the tag on the bus in that cycle.
- R11: Each cache keeps at most WAYS tags. A miss into a full directory evicts the tag allocated earliest among those still held. A Modified victim raises evict_wb_o with evict_tag_o, and a Shared victim is dropped with no strobe. A tag that leaves by invalidation frees its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NC | Access request per cache, held until done |
| req_write_i | input | NC | Access is a write |
| req_addr_i | input | NC*ADDR_W | Byte address per cache, cache c at [c*ADDR_W +: ADDR_W] |
| req_done_o | output | NC | Access completes this cycle |
| bus_valid_o | output | 1 | Bus message this cycle |
| bus_write_o | output | 1 | Message is write/invalidate (else read) |
| bus_src_o | output | SRC_W | Granted cache index |
| bus_tag_o | output | TAG_W | Block tag on the bus |
| mem_fill_o | output | 1 | Memory fill of bus_tag_o for the requester |
| mem_wb_o | output | 1 | Snooping Modified holder writes bus_tag_o back |
| evict_wb_o | output | 1 | Modified victim writeback |
| evict_tag_o | output | TAG_W | Tag of the evicted Modified block |
| probe_tag_i | input | TAG_W | Tag to inspect |
| probe_state_o | output | 2*NC | Per-cache state of probe_tag_i |

## Verification
The hardest cases to reach involve several caches acting on one block in the same cycle. One is a cache whose Shared read hit collides with another cache's granted write to that block. It must stall and then miss, which forces a writeback from the new owner. The other is three caches writing one block at once, so ownership passes around the round-robin order with a writeback at every handoff. The stimulus starts those accesses in the same step. It also fills one directory past its capacity behind a Modified entry to force an eviction writeback. A behavioural model holding a tag queue per cache is compared with every output and a rotating probe on every clock.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } msi_state_e;
endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  logic [IDX_W-1:0] ptr_q;

  function automatic int wrap_idx(input int v);
    return (v >= N) ? v - N : v;
  endfunction

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    valid_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!valid_o && req_i[wrap_idx(int'(ptr_q) + k)]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(wrap_idx(int'(ptr_q) + k));
        grant_o[wrap_idx(int'(ptr_q) + k)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (valid_o) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + 1'b1;
  end

  assert_grant_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_grant_requested_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0);
  assert_grant_when_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> valid_o);
endmodule

// File: rtl/msi_cache_dir.sv
module msi_cache_dir
  import msi_pkg::*;
#(
  parameter int TAG_W = 11,
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic             bus_mine_i,
  input  logic [TAG_W-1:0] bus_tag_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  output logic             need_bus_o,
  output msi_state_e       loc_state_o,
  output logic             snoop_wb_o,
  output logic             evict_o,
  output logic [TAG_W-1:0] evict_tag_o,
  output msi_state_e       probe_state_o
);
  logic [TAG_W-1:0] tag_q [WAYS];
  msi_state_e       st_q  [WAYS];
  logic [WAY_W-1:0] age_q [WAYS];  // allocation rank, 0 = newest

  logic             bus_hit, has_free;
  logic [WAY_W-1:0] bus_way, free_way, victim_way, alloc_way;

  function automatic msi_state_e look(input logic [TAG_W-1:0] t);
    msi_state_e r;
    r = ST_I;
    for (int w = 0; w < WAYS; w++)
      if (st_q[w] != ST_I && tag_q[w] == t) r = st_q[w];
    return r;
  endfunction

  always_comb begin
    bus_hit    = 1'b0;
    bus_way    = '0;
    has_free   = 1'b0;
    free_way   = '0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (st_q[w] != ST_I && tag_q[w] == bus_tag_i) begin
        bus_hit = 1'b1;
        bus_way = WAY_W'(w);
      end
      if (st_q[w] != ST_I && age_q[w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_q[w] == ST_I) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    alloc_way = has_free ? free_way : victim_way;
  end

  assign loc_state_o   = look(req_tag_i);
  assign probe_state_o = look(probe_tag_i);
  assign need_bus_o    = req_valid_i &&
                         (req_write_i ? (loc_state_o != ST_M) : (loc_state_o == ST_I));
  assign snoop_wb_o    = bus_valid_i && !bus_mine_i && bus_hit && st_q[bus_way] == ST_M;
  assign evict_o       = bus_valid_i && bus_mine_i && !bus_hit && !has_free &&
                         st_q[victim_way] == ST_M;
  assign evict_tag_o   = tag_q[victim_way];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w] <= '0;
        st_q[w]  <= ST_I;
        age_q[w] <= '0;
      end
    end else if (bus_valid_i && bus_mine_i) begin
      if (bus_hit) begin
        st_q[bus_way] <= ST_M;  // upgrade from Shared
      end else begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == alloc_way) begin
            tag_q[w] <= bus_tag_i;
            st_q[w]  <= bus_write_i ? ST_M : ST_S;
            age_q[w] <= '0;
          end else if (st_q[w] != ST_I) begin
            age_q[w] <= age_q[w] + 1'b1;
          end
        end
      end
    end else if (bus_valid_i && bus_hit) begin
      if (bus_write_i) begin
        st_q[bus_way] <= ST_I;
        for (int w = 0; w < WAYS; w++)
          if (st_q[w] != ST_I && age_q[w] > age_q[bus_way]) age_q[w] <= age_q[w] - 1'b1;
      end else if (st_q[bus_way] == ST_M) begin
        st_q[bus_way] <= ST_S;
      end
    end
  end

  // state of the previous cycle's bus tag, for the transition checks
  logic [TAG_W-1:0] trk_tag_q;
  msi_state_e       trk_st;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trk_tag_q <= '0;
    else         trk_tag_q <= bus_tag_i;
  end
  assign trk_st = look(trk_tag_q);

  assert_own_read_shared_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_mine_i && !bus_write_i) |=> trk_st == ST_S);
  assert_own_write_mod_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_mine_i && bus_write_i) |=> trk_st == ST_M);
  assert_snoop_write_inv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_mine_i && bus_write_i) |=> trk_st == ST_I);
  assert_snoop_drops_mod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_wb_o |=> trk_st != ST_M);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int NC     = 3,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 5,
  localparam int TAG_W = ADDR_W - OFFS_W,
  localparam int SRC_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NC-1:0]        req_valid_i,
  input  logic [NC-1:0]        req_write_i,
  input  logic [NC*ADDR_W-1:0] req_addr_i,
  output logic [NC-1:0]        req_done_o,
  output logic                 bus_valid_o,
  output logic                 bus_write_o,
  output logic [SRC_W-1:0]     bus_src_o,
  output logic [TAG_W-1:0]     bus_tag_o,
  output logic                 mem_fill_o,
  output logic                 mem_wb_o,
  output logic                 evict_wb_o,
  output logic [TAG_W-1:0]     evict_tag_o,
  input  logic [TAG_W-1:0]     probe_tag_i,
  output logic [2*NC-1:0]      probe_state_o
);
  logic [TAG_W-1:0] req_tag   [NC];
  logic [TAG_W-1:0] evt_tag   [NC];
  msi_state_e       loc_state [NC];
  msi_state_e       prb_state [NC];
  logic [NC-1:0]    need_bus, grant, snoop_wb, evict, unused_offs;
  logic [NC-1:0]    prb_m, prb_s;

  msi_rr_arb #(.N(NC), .IDX_W(SRC_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (need_bus),
    .grant_o(grant),
    .idx_o  (bus_src_o),
    .valid_o(bus_valid_o)
  );

  for (genvar c = 0; c < NC; c++) begin : g_cache
    assign req_tag[c]     = req_addr_i[c*ADDR_W+OFFS_W +: TAG_W];
    assign unused_offs[c] = ^req_addr_i[c*ADDR_W +: OFFS_W];

    msi_cache_dir #(.TAG_W(TAG_W), .WAYS(WAYS)) u_dir (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i[c]),
      .req_write_i  (req_write_i[c]),
      .req_tag_i    (req_tag[c]),
      .bus_valid_i  (bus_valid_o),
      .bus_write_i  (bus_write_o),
      .bus_mine_i   (grant[c]),
      .bus_tag_i    (bus_tag_o),
      .probe_tag_i  (probe_tag_i),
      .need_bus_o   (need_bus[c]),
      .loc_state_o  (loc_state[c]),
      .snoop_wb_o   (snoop_wb[c]),
      .evict_o      (evict[c]),
      .evict_tag_o  (evt_tag[c]),
      .probe_state_o(prb_state[c])
    );

    assign probe_state_o[2*c +: 2] = prb_state[c];
    assign prb_m[c] = prb_state[c] == ST_M;
    assign prb_s[c] = prb_state[c] == ST_S;
  end

  always_comb begin
    bus_tag_o   = '0;
    bus_write_o = 1'b0;
    mem_fill_o  = 1'b0;
    evict_tag_o = '0;
    for (int c = 0; c < NC; c++) begin
      if (grant[c]) begin
        bus_tag_o   = req_tag[c];
        bus_write_o = req_write_i[c];
        mem_fill_o  = loc_state[c] == ST_I;
      end
      if (evict[c]) evict_tag_o = evt_tag[c];
    end
  end

  assign mem_wb_o   = |snoop_wb;
  assign evict_wb_o = |evict;

  // bus users finish on grant; hits finish unless the bus is on their block
  always_comb begin
    for (int c = 0; c < NC; c++)
      req_done_o[c] = req_valid_i[c] &&
                      (need_bus[c] ? grant[c] : !(bus_valid_o && req_tag[c] == bus_tag_o));
  end

  assert_single_modified_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(prb_m) <= 1);
  assert_mod_excludes_shared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prb_m != '0) |-> (prb_s == '0));
  assert_wb_needs_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wb_o || evict_wb_o) |-> bus_valid_o);
endmodule

// File: tb/sim_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_msi_snoop_ctrl;
  localparam int NC = 3, WAYS = 4, AW = 16, OW = 5, TW = AW - OW, SW = 2;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0]   req_valid = '0, req_write = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0]   req_done;
  logic            bus_valid, bus_write, mem_fill, mem_wb, evict_wb;
  logic [SW-1:0]   bus_src;
  logic [TW-1:0]   bus_tag, evict_tag;
  logic [TW-1:0]   probe_tag = '0;
  logic [2*NC-1:0] probe_state;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  msi_snoop_ctrl #(.NC(NC), .WAYS(WAYS), .ADDR_W(AW), .OFFS_W(OW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_done_o(req_done),
    .bus_valid_o(bus_valid), .bus_write_o(bus_write), .bus_src_o(bus_src),
    .bus_tag_o(bus_tag), .mem_fill_o(mem_fill), .mem_wb_o(mem_wb),
    .evict_wb_o(evict_wb), .evict_tag_o(evict_tag),
    .probe_tag_i(probe_tag), .probe_state_o(probe_state)
  );

  // reference model: per-cache tag queue in allocation order plus state map
  int unsigned fifo_q [NC][$];
  int          st_m   [NC][int unsigned];
  int          rr_ptr = 0;
  bit          pv [NC];
  bit          pw [NC];
  int unsigned pa [NC];
  int unsigned probe_list [8] = '{'h080, 'h100, 'h180, 'h200, 'h500, 'h580, 'h600, 'h680};
  int          pidx = 0;
  string       tag_lbl = "";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mget(input int c, input int unsigned t);
    return st_m[c].exists(t) ? st_m[c][t] : 0;
  endfunction

  task automatic drop(input int c, input int unsigned t);
    st_m[c].delete(t);
    foreach (fifo_q[c][i]) if (fifo_q[c][i] == t) begin fifo_q[c].delete(i); break; end
  endtask

  task automatic cycle();
    bit need [NC];
    bit edone [NC];
    int g = -1;
    int unsigned gtag = 0, ptag;
    bit gw = 0, efill = 0, ewb = 0, eev = 0;
    int unsigned eevt = 0;
    int mcnt = 0, scnt = 0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = pv[c];
      req_write[c] = pw[c];
      req_addr[c*AW +: AW] = AW'(pa[c]);
    end
    ptag = probe_list[pidx % 8];
    probe_tag = TW'(ptag);
    pidx++;
    #1;
    for (int c = 0; c < NC; c++) begin
      int s = mget(c, pa[c] >> OW);
      need[c] = pv[c] && (pw[c] ? s != 2 : s == 0);
    end
    for (int k = 0; k < NC; k++) begin
      int j = (rr_ptr + k) % NC;
      if (g < 0 && need[j]) g = j;
    end
    if (g >= 0) begin
      gtag = pa[g] >> OW;
      gw = pw[g];
      efill = mget(g, gtag) == 0;
      if (efill && fifo_q[g].size() == WAYS && mget(g, fifo_q[g][0]) == 2) begin
        eev = 1; eevt = fifo_q[g][0];
      end
      for (int c = 0; c < NC; c++) if (c != g && mget(c, gtag) == 2) ewb = 1;
    end
    for (int c = 0; c < NC; c++) begin
      edone[c] = pv[c] && (need[c] ? c == g : !(g >= 0 && (pa[c] >> OW) == gtag));
      chk(req_done[c] == edone[c], "R4,R9,R10", {"done ", tag_lbl}, req_done[c], edone[c]);
    end
    chk(bus_valid == (g >= 0), "R2,R3,R9", {"bus_valid ", tag_lbl}, bus_valid, g >= 0);
    if (g >= 0 && bus_valid) begin
      chk(bus_src == SW'(g), "R9", "bus_src", bus_src, g);
      chk(bus_tag == TW'(gtag), "R7", "bus_tag", bus_tag, gtag);
      chk(bus_write == gw, "R2,R3", "bus_write", bus_write, gw);
    end
    chk(mem_fill == efill, "R2", "mem_fill", mem_fill, efill);
    chk(mem_wb == ewb, "R6", "mem_wb", mem_wb, ewb);
    chk(evict_wb == eev, "R11", "evict_wb", evict_wb, eev);
    if (eev) chk(evict_tag == TW'(eevt), "R11", "evict_tag", evict_tag, eevt);
    for (int c = 0; c < NC; c++) begin
      int ps = int'(probe_state[2*c +: 2]);
      chk(ps == mget(c, ptag), "R5,R11", "probe_state", ps, mget(c, ptag));
      if (ps == 2) mcnt++;
      if (ps == 1) scnt++;
    end
    chk(mcnt <= 1 && !(mcnt == 1 && scnt > 0), "R8", "modified count", mcnt, 1);
    // advance model to the post-edge state
    if (g >= 0) begin
      if (mget(g, gtag) == 0) begin
        if (fifo_q[g].size() == WAYS) begin
          int unsigned v = fifo_q[g].pop_front();
          st_m[g].delete(v);
        end
        fifo_q[g].push_back(gtag);
        st_m[g][gtag] = gw ? 2 : 1;
      end else begin
        st_m[g][gtag] = 2;
      end
      for (int c = 0; c < NC; c++) begin
        if (c != g && st_m[c].exists(gtag)) begin
          if (gw) drop(c, gtag);
          else if (st_m[c][gtag] == 2) st_m[c][gtag] = 1;
        end
      end
      rr_ptr = (g + 1) % NC;
    end
    for (int c = 0; c < NC; c++) if (edone[c]) pv[c] = 0;
  endtask

  task automatic run_step();
    int n = 0;
    while ((pv[0] || pv[1] || pv[2]) && n < 20) begin
      cycle();
      n++;
    end
    chk(!(pv[0] || pv[1] || pv[2]), "R9", "step stalled", n, 0);
    for (int c = 0; c < NC; c++) pv[c] = 0;
  endtask

  task automatic acc(input int c, input bit w, input int unsigned a);
    pv[c] = 1; pw[c] = w; pa[c] = a;
  endtask

  task automatic one(input int c, input bit w, input int unsigned a);
    acc(c, w, a);
    run_step();
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog R9 act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin pv[c] = 0; pw[c] = 0; pa[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle probes over all listed tags right after reset
    for (int i = 0; i < 8; i++) begin
      cycle();
      chk(probe_state == '0, "R1", "reset state", probe_state, 0);
    end
    // two-range sequence
    one(0, 0, 'h1000);
    one(1, 0, 'h1000);
    one(0, 1, 'h1000);
    one(0, 0, 'h2000);
    one(1, 0, 'h1000);   // R6: cache 0 Modified gives up on snooped read
    one(1, 1, 'h2008);   // R7: same block as 0x2000
    one(2, 0, 'h1008);
    // R7: offset-only difference hits the block already held
    tag_lbl = "R7";
    one(2, 0, 'h101f);
    one(1, 1, 'h2010);   // R3: Modified hit, no bus
    tag_lbl = "";
    one(0, 1, 'h2018);   // R5/R6: snooped write steals Modified
    one(0, 0, 'h2000);   // R4: read hit on Modified
    // R9: three writers to one block at once
    acc(0, 1, 'h3000); acc(1, 1, 'h3008); acc(2, 1, 'h3010);
    run_step();
    // R9: three readers of a fresh block at once
    acc(0, 0, 'h4000); acc(1, 0, 'h4000); acc(2, 0, 'h4000);
    run_step();
    // R10: Shared read hit collides with another cache's granted write
    acc(0, 0, 'h4000); acc(1, 1, 'h4000);
    run_step();
    // R11: overfill cache 2 behind a Modified entry
    one(2, 1, 'hA000);
    one(2, 0, 'hB000);
    one(2, 0, 'hC000);
    one(2, 0, 'hD000);
    one(2, 0, 'hE000);
    one(2, 0, 'hB000);
    one(2, 0, 'h1000);
    // idle probes to sweep final states
    for (int i = 0; i < 8; i++) cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule